// File: doc/BRIEF.md
# I2C Command-Framed Target Interface

This block is the serial front end of a device whose internal storage is reached through a command byte and a 16-bit address. It watches a two-wire I2C bus through a synchronizer into the system clock and recognises START, repeated START and STOP. For each frame it accepts the target address, a command byte, the address high byte and the address low byte. It then moves data in one of two ways. It takes in write bytes and presents each one as a single-cycle strobe on a parallel port. For a read, it fetches each byte through a request/response pair and shifts it out on SDA.

The command byte sets both the direction and the byte count. Command bit 7 selects a read when it is 1 and a write when it is 0. Bits 2:0 give the count minus one, so a frame carries 1 to 8 bytes. A read takes two phases. A write-addressed setup phase delivers the command and the address, and the block then keeps that setup pending. A repeated START with the read bit set then starts the data phase. SDA is open drain: `sda_oe_o` high pulls the line low.

Top module: `i2c_cmd_target`

## Requirements
- R1: START is an SDA fall while SCL is high, and STOP is an SDA rise while SCL is high. Both are sampled after a two-stage synchronizer. Bytes sent after a STOP without a new START are not acknowledged.
- R2: A first byte whose upper seven bits equal `DEV_ADDR` (default 7'h2C) is acknowledged. Any other value is not acknowledged, and the block produces no strobe or acknowledge until the next START.
- R3: A command byte with bit 7 = 0 is a write and one with bit 7 = 1 is a read. Bits 2:0 plus one give the number of data bytes.
- R4: The first address byte is bits 15:8 of `addr_o` and the second is bits 7:0. `cmd_o` holds the received command byte.
- R5: Each accepted write byte is acknowledged and gives one `wr_stb_o` cycle, with `wr_data_o` and `addr_o` valid in that cycle. `addr_o` then increments by one, with carry across the low byte.
- R6: Write bytes beyond the command's count are not acknowledged and produce no strobe.
- R7: All four bytes of a read setup are acknowledged and the read stays pending. After a repeated START, a matching address with R/W=1 is acknowledged only when a read is pending.
- R8: Read bytes go out MSB first. Each byte inside the count raises `rd_req_o` for one cycle with `addr_o` valid, samples `rd_data_i` in that same cycle, and then increments `addr_o`.
- R9: When the read count is used up, the block keeps sending the pad byte 8'h00 while the master acknowledges, and it does not raise `rd_req_o`.
- R10: A master NACK after a read byte releases SDA and ends the frame.
- R11: A STOP, or any START that is not the repeated START of a pending read, clears the pending read. A later R/W=1 address is then not acknowledged.
- R12: `sda_oe_o` changes only while SCL is low, and `wr_stb_o` and `rd_req_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin |
| sda_oe_o | output | 1 | Pull SDA low when high |
| cmd_o | output | 8 | Received command byte |
| addr_o | output | 16 | Current internal address |
| wr_stb_o | output | 1 | One-cycle write strobe |
| wr_data_o | output | 8 | Write byte, valid with the strobe |
| rd_req_o | output | 1 | One-cycle read request |
| rd_data_i | input | 8 | Read byte, sampled while the request is high |

## Verification
On every cycle the assertions check the single-cycle shape of the write strobe and the read request, that the two never coincide, that the address steps by one after each of them, and that SDA drive changes only during SCL low. Only the bench scenarios can show the framing itself. These cover the acknowledge pattern for matching and non-matching addresses, byte counts taken from the command including the one-byte and eight-byte limits, the read-count overrun into pad bytes, and the loss of a pending read at STOP. The bench also checks the exact sequence of strobed addresses and data against a scoreboard.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

    localparam int CNT_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_WAIT,
        ST_LOAD,
        ST_TX,
        ST_MACK
    } state_t;

    typedef enum logic [2:0] {
        PH_SADDR,
        PH_CMD,
        PH_AHI,
        PH_ALO,
        PH_DATA
    } phase_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic             is_read;
        logic [CNT_W-1:0] count;
    } cmd_info_t;

    function automatic cmd_info_t decode_cmd(input logic [7:0] c);
        cmd_info_t r;
        r.is_read = c[7];
        r.count   = {1'b0, c[2:0]} + CNT_W'(1);
        return r;
    endfunction

endpackage

// File: rtl/i2c_cmd_sync.sv
module i2c_cmd_sync
    import i2c_cmd_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);
    logic [STAGES-1:0] scl_q, sda_q;
    logic              scl_p, sda_p;
    logic              scl_s, sda_s;

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    always_comb begin
        ev_o.start    = scl_s & scl_p & sda_p & ~sda_s;
        ev_o.stop     = scl_s & scl_p & ~sda_p & sda_s;
        ev_o.scl_rise = scl_s & ~scl_p;
        ev_o.scl_fall = ~scl_s & scl_p;
        ev_o.sda      = sda_s;
    end
endmodule

// File: rtl/i2c_cmd_decode.sv
module i2c_cmd_decode
    import i2c_cmd_pkg::*;
(
    input  logic [7:0] cmd_i,
    output cmd_info_t  info_o
);
    assign info_o = decode_cmd(cmd_i);
endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
    import i2c_cmd_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2C,
    parameter logic [7:0] PAD_BYTE = 8'h00
) (
    input  logic        clk,
    input  logic        rst,
    input  bus_ev_t     ev_i,
    input  cmd_info_t   info_i,
    input  logic [7:0]  rd_data_i,
    output logic        sda_oe_o,
    output logic [7:0]  cmd_o,
    output logic [15:0] addr_o,
    output logic        wr_stb_o,
    output logic [7:0]  wr_data_o,
    output logic        rd_req_o
);
    state_t           st, after_st;
    phase_t           ph;
    logic [7:0]       sh;
    logic [2:0]       bcnt;
    logic             byte_rdy;
    logic             pend;
    logic             mack;
    logic [CNT_W-1:0] left;
    logic [7:0]       tx_byte;

    assign tx_byte = (left != '0) ? rd_data_i : PAD_BYTE;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            after_st  <= ST_IDLE;
            ph        <= PH_SADDR;
            sh        <= '0;
            bcnt      <= '0;
            byte_rdy  <= 1'b0;
            pend      <= 1'b0;
            mack      <= 1'b0;
            left      <= '0;
            sda_oe_o  <= 1'b0;
            cmd_o     <= '0;
            addr_o    <= '0;
            wr_stb_o  <= 1'b0;
            wr_data_o <= '0;
            rd_req_o  <= 1'b0;
        end else begin
            wr_stb_o <= 1'b0;
            rd_req_o <= 1'b0;
            if (wr_stb_o || rd_req_o)
                addr_o <= addr_o + 16'd1;

            if (ev_i.stop) begin
                st       <= ST_IDLE;
                sda_oe_o <= 1'b0;
                pend     <= 1'b0;
            end else if (ev_i.start) begin
                if (st != ST_WAIT)
                    pend <= 1'b0;
                st       <= ST_RX;
                ph       <= PH_SADDR;
                bcnt     <= '0;
                byte_rdy <= 1'b0;
                sda_oe_o <= 1'b0;
            end else begin
                unique case (st)
                    ST_RX: begin
                        if (ev_i.scl_rise && !byte_rdy) begin
                            sh   <= {sh[6:0], ev_i.sda};
                            bcnt <= bcnt + 3'd1;
                            if (bcnt == 3'd7)
                                byte_rdy <= 1'b1;
                        end else if (ev_i.scl_fall && byte_rdy) begin
                            byte_rdy <= 1'b0;
                            st       <= ST_ACK;
                            sda_oe_o <= 1'b1;
                            after_st <= ST_RX;
                            unique case (ph)
                                PH_SADDR: begin
                                    if (sh[7:1] != DEV_ADDR) begin
                                        st       <= ST_IDLE;
                                        sda_oe_o <= 1'b0;
                                    end else if (sh[0]) begin
                                        if (pend) begin
                                            after_st <= ST_LOAD;
                                            pend     <= 1'b0;
                                        end else begin
                                            st       <= ST_IDLE;
                                            sda_oe_o <= 1'b0;
                                        end
                                    end else begin
                                        pend <= 1'b0;
                                        ph   <= PH_CMD;
                                    end
                                end
                                PH_CMD: begin
                                    cmd_o <= sh;
                                    ph    <= PH_AHI;
                                end
                                PH_AHI: begin
                                    addr_o[15:8] <= sh;
                                    ph           <= PH_ALO;
                                end
                                PH_ALO: begin
                                    addr_o[7:0] <= sh;
                                    left        <= info_i.count;
                                    if (info_i.is_read) begin
                                        pend     <= 1'b1;
                                        after_st <= ST_WAIT;
                                    end else begin
                                        ph <= PH_DATA;
                                    end
                                end
                                default: begin
                                    if (left != '0) begin
                                        wr_stb_o  <= 1'b1;
                                        wr_data_o <= sh;
                                        left      <= left - CNT_W'(1);
                                    end else begin
                                        st       <= ST_IDLE;
                                        sda_oe_o <= 1'b0;
                                    end
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (ev_i.scl_fall) begin
                            sda_oe_o <= 1'b0;
                            bcnt     <= '0;
                            st       <= after_st;
                            if (after_st == ST_LOAD)
                                rd_req_o <= (left != '0);
                        end
                    end
                    ST_LOAD: begin
                        sh       <= tx_byte;
                        sda_oe_o <= ~tx_byte[7];
                        bcnt     <= '0;
                        if (left != '0)
                            left <= left - CNT_W'(1);
                        st <= ST_TX;
                    end
                    ST_TX: begin
                        if (ev_i.scl_fall) begin
                            if (bcnt == 3'd7) begin
                                sda_oe_o <= 1'b0;
                                mack     <= 1'b0;
                                st       <= ST_MACK;
                            end else begin
                                sh       <= {sh[6:0], 1'b0};
                                sda_oe_o <= ~sh[6];
                                bcnt     <= bcnt + 3'd1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (ev_i.scl_rise) begin
                            mack <= ~ev_i.sda;
                        end else if (ev_i.scl_fall) begin
                            if (mack) begin
                                st       <= ST_LOAD;
                                rd_req_o <= (left != '0);
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_cmd_target.sv
module i2c_cmd_target
    import i2c_cmd_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h2C,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] PAD_BYTE    = 8'h00
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe_o,
    output logic [7:0]  cmd_o,
    output logic [15:0] addr_o,
    output logic        wr_stb_o,
    output logic [7:0]  wr_data_o,
    output logic        rd_req_o,
    input  logic [7:0]  rd_data_i
);
    bus_ev_t   ev;
    cmd_info_t info;

    i2c_cmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    i2c_cmd_decode u_dec (
        .cmd_i  (cmd_o),
        .info_o (info)
    );

    i2c_cmd_engine #(.DEV_ADDR(DEV_ADDR), .PAD_BYTE(PAD_BYTE)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .ev_i      (ev),
        .info_i    (info),
        .rd_data_i (rd_data_i),
        .sda_oe_o  (sda_oe_o),
        .cmd_o     (cmd_o),
        .addr_o    (addr_o),
        .wr_stb_o  (wr_stb_o),
        .wr_data_o (wr_data_o),
        .rd_req_o  (rd_req_o)
    );
endmodule

// File: rtl/i2c_cmd_target_chk.sv
module i2c_cmd_target_chk (
    input logic        clk,
    input logic        rst,
    input logic        scl_i,
    input logic        sda_oe_o,
    input logic [15:0] addr_o,
    input logic        wr_stb_o,
    input logic        rd_req_o
);
    AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |=> !wr_stb_o); // R5

    AST_WR_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |=> addr_o == $past(addr_o) + 16'd1); // R5

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rd_req_o |=> !rd_req_o); // R8

    AST_RD_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        rd_req_o |=> addr_o == $past(addr_o) + 16'd1); // R8

    AST_NO_STB_REQ_MIX: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb_o && rd_req_o)); // R12

    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe_o) |-> !scl_i); // R12
endmodule

bind i2c_cmd_target i2c_cmd_target_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_oe_o (sda_oe_o),
    .addr_o   (addr_o),
    .wr_stb_o (wr_stb_o),
    .rd_req_o (rd_req_o)
);

// File: tb/i2c_cmd_target_bench.sv
module i2c_cmd_target_bench;
    localparam int Q = 10;
    localparam logic [6:0] DEV = 7'h2C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_oe;
    logic [7:0]  cmd;
    logic [15:0] addr;
    logic        wr_stb;
    logic [7:0]  wr_data;
    logic        rd_req;
    logic [7:0]  rd_data;
    wire         sda_line = m_sda & ~sda_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    assign rd_data = addr[7:0] ^ 8'h5A;

    i2c_cmd_target u_i2c_cmd_target (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (m_scl),
        .sda_i     (sda_line),
        .sda_oe_o  (sda_oe),
        .cmd_o     (cmd),
        .addr_o    (addr),
        .wr_stb_o  (wr_stb),
        .wr_data_o (wr_data),
        .rd_req_o  (rd_req),
        .rd_data_i (rd_data)
    );

    logic [23:0] exp_wr[$];
    logic [15:0] exp_rd[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && wr_stb) begin
            if (exp_wr.size() == 0)
                chk(1'b0, "R6 unexpected write strobe", {addr, wr_data}, 0);
            else begin
                logic [23:0] e;
                e = exp_wr.pop_front();
                chk({addr, wr_data} == e, "R5 write addr/data", {addr, wr_data}, e);
            end
        end
        if (!rst && rd_req) begin
            if (exp_rd.size() == 0)
                chk(1'b0, "R9 unexpected read request", addr, 0);
            else begin
                logic [15:0] e;
                e = exp_rd.pop_front();
                chk(addr == e, "R8 read request addr", addr, e);
            end
        end
    end

    task automatic q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; q(); m_scl = 1'b1; q(); m_sda = 1'b0; q(); m_scl = 1'b0; q();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; q(); m_scl = 1'b1; q(); m_sda = 1'b1; q(); q();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; q(); m_scl = 1'b1; q(); q(); m_scl = 1'b0; q();
        end
        m_sda = 1'b1; q(); m_scl = 1'b1; q();
        ack = ~sda_line;
        q(); m_scl = 1'b0; q();
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit give_ack);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            q(); m_scl = 1'b1; q(); b[i] = sda_line; q(); m_scl = 1'b0;
        end
        m_sda = ~give_ack; q(); m_scl = 1'b1; q(); q(); m_scl = 1'b0; q();
        m_sda = 1'b1;
    endtask

    task automatic write_frame(input logic [7:0] c, input logic [15:0] a,
                               input int n, input logic [7:0] seed);
        bit ack;
        int cnt;
        cnt = int'(c[2:0]) + 1;
        bus_start();
        send_byte({DEV, 1'b0}, ack); chk(ack, "R2 address ack", ack, 1);
        send_byte(c, ack);           chk(ack, "R3 command ack", ack, 1);
        send_byte(a[15:8], ack);     chk(ack, "R4 high addr ack", ack, 1);
        send_byte(a[7:0], ack);      chk(ack, "R4 low addr ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = seed + 8'(i * 17);
            if (i < cnt) exp_wr.push_back({a + 16'(i), d});
            send_byte(d, ack);
            if (i < cnt) chk(ack, "R5 data ack within count", ack, 1);
            else         chk(!ack, "R6 data beyond count nacked", ack, 0);
        end
        chk(cmd == c, "R4 command register", cmd, c);
        bus_stop();
    endtask

    initial begin
        bit ack;
        logic [7:0] b;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(sda_oe == 1'b0, "R12 reset sda released", sda_oe, 0);
        chk(wr_stb == 1'b0 && rd_req == 1'b0, "R12 reset no strobes", {wr_stb, rd_req}, 0);
        q();

        // R3 R4 R5 R6: three-byte write crossing the low-byte boundary, one extra byte
        write_frame(8'h02, 16'h12FE, 4, 8'hA1);
        chk(exp_wr.size() == 0, "R5 all writes seen", exp_wr.size(), 0);
        // R3: one-byte and eight-byte counts
        write_frame(8'h00, 16'h0040, 2, 8'h33);
        write_frame(8'h07, 16'hBEEF, 9, 8'h10);
        chk(exp_wr.size() == 0, "R3 count writes seen", exp_wr.size(), 0);

        // R2: wrong target address ignored until next START
        bus_start();
        send_byte({7'h2D, 1'b0}, ack); chk(!ack, "R2 mismatch nacked", ack, 0);
        send_byte(8'h02, ack);         chk(!ack, "R2 ignored after mismatch", ack, 0);
        bus_stop();

        // R1: bytes after STOP without START are not acknowledged
        send_byte({DEV, 1'b0}, ack);   chk(!ack, "R1 no ack without START", ack, 0);
        bus_stop();

        // R7 R8 R9 R10: read setup, repeated START, overrun into pad bytes
        bus_start();
        send_byte({DEV, 1'b0}, ack); chk(ack, "R7 setup address ack", ack, 1);
        send_byte(8'h81, ack);       chk(ack, "R7 read command ack", ack, 1);
        send_byte(8'h00, ack);       chk(ack, "R7 high addr ack", ack, 1);
        send_byte(8'hFF, ack);       chk(ack, "R7 low addr ack", ack, 1);
        exp_rd.push_back(16'h00FF);
        exp_rd.push_back(16'h0100);
        bus_start();
        send_byte({DEV, 1'b1}, ack); chk(ack, "R7 read address ack", ack, 1);
        recv_byte(b, 1'b1); chk(b == 8'hA5, "R8 first read byte", b, 8'hA5);
        recv_byte(b, 1'b1); chk(b == 8'h5A, "R8 second read byte", b, 8'h5A);
        recv_byte(b, 1'b1); chk(b == 8'h00, "R9 pad byte", b, 0);
        recv_byte(b, 1'b0); chk(b == 8'h00, "R9 pad byte before nack", b, 0);
        q();
        chk(sda_oe == 1'b0, "R10 sda released after nack", sda_oe, 0);
        chk(exp_rd.size() == 0, "R8 all requests seen", exp_rd.size(), 0);
        bus_stop();

        // R11: STOP clears a pending read
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h83, ack);
        send_byte(8'h12, ack);
        send_byte(8'h34, ack); chk(ack, "R11 setup acked", ack, 1);
        bus_stop();
        bus_start();
        send_byte({DEV, 1'b1}, ack); chk(!ack, "R11 read after STOP nacked", ack, 0);
        bus_stop();

        // R7: read address without any setup
        bus_start();
        send_byte({DEV, 1'b1}, ack); chk(!ack, "R7 read without setup nacked", ack, 0);
        bus_stop();

        chk(exp_wr.size() == 0 && exp_rd.size() == 0, "R12 scoreboard empty",
            exp_wr.size() + exp_rd.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule